// File: doc/BRIEF.md
# Vectored Interrupt Controller with Status

This block gathers the four interrupt causes of one serial channel: transmitter ready for a new byte, change on a modem or status line, a received byte waiting, and a receive error or end-of-frame condition. Each cause is held in a pending latch. A latch is only set when its own enable allows it. The channel raises one request line while the master enable is on and at least one latch is set.

When the processor runs an interrupt acknowledge cycle, the block captures an 8-bit vector and holds it for the whole cycle. When status inclusion is on, a 3-bit code for the highest-priority pending cause overwrites three bits of a programmable base vector. The processor can therefore branch straight to a handler for that cause. A separate end-of-service strobe clears the latch of the cause that was served. The receive path has a first-byte mode, which requests service only for the first byte after it is armed. The block also keeps a byte-available status flag that does not depend on the interrupt mode.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After hardware reset, `irq`, `pend`, `vec` and `rx_avail` are all zero, the master enable is off, the receive mode is off and first-byte mode is armed.
- R2: A pulse on `cfg_wr` loads every `cfg_*` input, and the new values govern from the next cycle. While the master enable is 0, `irq` stays low, but pending bits are still set.
- R3: `irq` is high exactly when the master enable is 1 and at least one `pend` bit is set. A source strobe shows in `pend` and `irq` one cycle after the edge that samples it.
- R4: `pend` bit 0 is transmitter-ready and is set by `ev_txe` only when `cfg_txe_en` is 1. Bit 1 is status change and is set by `ev_ext` only when `cfg_ext_en` is 1. Each enable works independently of the other sources.
- R5: `cfg_rx_mode` 00 blocks both receive sources. With 01 or 1x, `ev_spc` sets `pend` bit 3. With 1x, every `ev_rxc` sets `pend` bit 2.
- R6: With mode 01, `ev_rxc` sets `pend` bit 2 only while armed, and doing so disarms. A `rx_rearm` pulse arms again, and it wins over a disarm in the same cycle.
- R7: `rx_avail` is set by every `ev_rxc` in any mode and cleared by `rx_take`. A set wins over a clear in the same cycle.
- R8: When several sources are pending, the served order is bit 3, then bit 2, then bit 0, then bit 1.
- R9: On the first cycle that `iack` is high, `vec` is loaded, and it is visible on the next cycle. It stays unchanged until the next rising `iack`.
- R10: When status inclusion is on and a source is pending, `vec` equals the base with bits 3:1 replaced by 100 (bit 0), 101 (bit 1), 110 (bit 2) or 111 (bit 3). A base of 0x20 gives 0x28, 0x2A, 0x2C and 0x2E.
- R11: When status inclusion is off, or nothing is pending at the acknowledge, `vec` equals the base unchanged.
- R12: `irq_clr` clears only the `pend` bit of the source captured by the last acknowledge, and only once. An acknowledge by itself clears nothing. A new strobe of the same source in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ev_txe | input | 1 | Transmitter-ready event strobe |
| ev_ext | input | 1 | Status-change event strobe |
| ev_rxc | input | 1 | Received-byte event strobe |
| ev_spc | input | 1 | Receive error / end-of-frame event strobe |
| rx_take | input | 1 | Byte read by software, clears `rx_avail` |
| rx_rearm | input | 1 | Arms first-byte mode again |
| cfg_wr | input | 1 | Load configuration strobe |
| cfg_mie | input | 1 | Master interrupt enable |
| cfg_vis | input | 1 | Status inclusion in vector |
| cfg_txe_en | input | 1 | Transmitter-ready source enable |
| cfg_ext_en | input | 1 | Status-change source enable |
| cfg_rx_mode | input | 2 | Receive interrupt mode: 00 off, 01 first byte, 1x every byte |
| cfg_base | input | 8 | Base vector |
| iack | input | 1 | Interrupt acknowledge cycle active |
| irq_clr | input | 1 | End-of-service strobe |
| irq | output | 1 | Interrupt request |
| vec | output | 8 | Vector returned during acknowledge |
| pend | output | 4 | Pending latches: 0 tx-ready, 1 status, 2 rx byte, 3 rx special |
| rx_avail | output | 1 | Received byte waiting |

## Verification
A corrupted pending latch appears on `pend` in the next cycle. It also appears on `irq` in the same cycle when the master enable is on, and in the vector code at the following acknowledge. A wrong served-source register shows only later, at the next `irq_clr`, when the wrong `pend` bit drops. A stuck arming flag in first-byte mode shows at the first received byte after a clear or a re-arm. The bench therefore compares `irq`, `pend`, `vec` and `rx_avail` against its model on every cycle.

// File: rtl/vic_pkg.sv
package vic_pkg;
   localparam int NSRC = 4;

   // bit positions in the pending vector
   typedef enum logic [1:0] {
      SRC_TXE = 2'd0,
      SRC_EXT = 2'd1,
      SRC_RXC = 2'd2,
      SRC_SPC = 2'd3
   } src_e;

   typedef enum logic [1:0] {
      RXI_OFF   = 2'b00,
      RXI_FIRST = 2'b01,
      RXI_ALL   = 2'b10,
      RXI_ALLB  = 2'b11
   } rxi_e;

   typedef struct packed {
      logic mie;
      logic vis;
      logic txe_en;
      logic ext_en;
      rxi_e rxm;
   } cfg_t;

   // status code placed into the vector: leading one, then the source index
   function automatic logic [2:0] src_code(src_e s);
      return {1'b1, s};
   endfunction
endpackage

// File: rtl/vic_pend_cell.sv
module vic_pend_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   // a fresh event wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/vic_prio.sv
module vic_prio
   import vic_pkg::*;
#(
   parameter int N = NSRC
) (
   input  logic [N-1:0] req,
   output logic         any,
   output src_e         top
);
   if (N != 4) begin : g_bad_n
      $error("vic_prio supports exactly four sources");
   end

   // lowest priority first; later entries override earlier ones
   localparam src_e ORDER [N] = '{SRC_EXT, SRC_TXE, SRC_RXC, SRC_SPC};

   always_comb begin
      top = SRC_EXT;
      for (int i = 0; i < N; i++) begin
         if (req[ORDER[i]]) top = ORDER[i];
      end
      any = |req;
   end
endmodule

// File: rtl/vic_vec_fmt.sv
module vic_vec_fmt
   import vic_pkg::*;
#(
   parameter int VEC_W     = 8,
   parameter bit STAT_HIGH = 1'b0
) (
   input  logic [VEC_W-1:0] base,
   input  logic             vis,
   input  logic             any,
   input  src_e             top,
   output logic [VEC_W-1:0] vec
);
   localparam int CODE_W   = 3;
   localparam int CODE_LSB = STAT_HIGH ? (VEC_W - 1 - CODE_W) : 1;

   if (VEC_W < 8) begin : g_bad_w
      $error("vic_vec_fmt needs at least an 8-bit vector");
   end

   logic [CODE_W-1:0] code;
   logic [VEC_W-1:0]  mask;
   logic [VEC_W-1:0]  ins;

   assign code = src_code(top);

   if (STAT_HIGH) begin : g_high
      assign mask = {{(VEC_W-CODE_LSB-CODE_W){1'b0}}, {CODE_W{1'b1}}, {CODE_LSB{1'b0}}};
      assign ins  = {{(VEC_W-CODE_LSB-CODE_W){1'b0}}, code, {CODE_LSB{1'b0}}};
   end else begin : g_low
      assign mask = {{(VEC_W-CODE_W-1){1'b0}}, {CODE_W{1'b1}}, 1'b0};
      assign ins  = {{(VEC_W-CODE_W-1){1'b0}}, code, 1'b0};
   end

   always_comb begin
      if (vis && any) vec = (base & ~mask) | ins;
      else            vec = base;
   end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import vic_pkg::*;
#(
   parameter int               VEC_W     = 8,
   parameter bit               STAT_HIGH = 1'b0,
   parameter logic [VEC_W-1:0] BASE_RST  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_txe,
   input  logic             ev_ext,
   input  logic             ev_rxc,
   input  logic             ev_spc,
   input  logic             rx_take,
   input  logic             rx_rearm,
   input  logic             cfg_wr,
   input  logic             cfg_mie,
   input  logic             cfg_vis,
   input  logic             cfg_txe_en,
   input  logic             cfg_ext_en,
   input  logic [1:0]       cfg_rx_mode,
   input  logic [VEC_W-1:0] cfg_base,
   input  logic             iack,
   input  logic             irq_clr,
   output logic             irq,
   output logic [VEC_W-1:0] vec,
   output logic [NSRC-1:0]  pend,
   output logic             rx_avail
);
   cfg_t             cfg_q;
   logic [VEC_W-1:0] base_q;
   logic             armed_q;
   logic             rxav_q;
   logic             iack_q;
   src_e             serv_q;
   logic             serv_v;
   logic [VEC_W-1:0] vec_q;

   logic [NSRC-1:0]  set_v;
   logic [NSRC-1:0]  clr_v;
   logic             rx_first;
   logic             rx_all;
   logic             take_first;
   logic             any;
   src_e             top;
   logic             ack_rise;
   logic [VEC_W-1:0] vec_nx;

   // configuration register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '{mie: 1'b0, vis: 1'b0, txe_en: 1'b0, ext_en: 1'b0, rxm: RXI_OFF};
         base_q <= BASE_RST;
      end else if (cfg_wr) begin
         cfg_q  <= '{mie: cfg_mie, vis: cfg_vis, txe_en: cfg_txe_en,
                     ext_en: cfg_ext_en, rxm: rxi_e'(cfg_rx_mode)};
         base_q <= cfg_base;
      end
   end

   // source gating
   assign rx_first   = (cfg_q.rxm == RXI_FIRST);
   assign rx_all     = cfg_q.rxm[1];
   assign take_first = ev_rxc & rx_first & armed_q;

   always_comb begin
      set_v          = '0;
      set_v[SRC_TXE] = ev_txe & cfg_q.txe_en;
      set_v[SRC_EXT] = ev_ext & cfg_q.ext_en;
      set_v[SRC_RXC] = (ev_rxc & rx_all) | take_first;
      set_v[SRC_SPC] = ev_spc & (cfg_q.rxm != RXI_OFF);
   end

   always_comb begin
      clr_v = '0;
      if (irq_clr && serv_v) clr_v[serv_q] = 1'b1;
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_cell
      vic_pend_cell u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (set_v[i]),
         .clr   (clr_v[i]),
         .q     (pend[i])
      );
   end

   // first-byte arming and byte-available status
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         rxav_q  <= 1'b0;
      end else begin
         if (rx_rearm)        armed_q <= 1'b1;
         else if (take_first) armed_q <= 1'b0;
         if (ev_rxc)          rxav_q  <= 1'b1;
         else if (rx_take)    rxav_q  <= 1'b0;
      end
   end

   vic_prio #(.N(NSRC)) u_prio (
      .req (pend),
      .any (any),
      .top (top)
   );

   vic_vec_fmt #(.VEC_W(VEC_W), .STAT_HIGH(STAT_HIGH)) u_fmt (
      .base (base_q),
      .vis  (cfg_q.vis),
      .any  (any),
      .top  (top),
      .vec  (vec_nx)
   );

   // acknowledge capture and served-source tracking
   assign ack_rise = iack & ~iack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iack_q <= 1'b0;
         vec_q  <= '0;
         serv_q <= SRC_EXT;
         serv_v <= 1'b0;
      end else begin
         iack_q <= iack;
         if (ack_rise) begin
            vec_q  <= vec_nx;
            serv_q <= top;
            serv_v <= any;
         end else if (irq_clr) begin
            serv_v <= 1'b0;
         end
      end
   end

   assign irq      = cfg_q.mie & any;
   assign vec      = vec_q;
   assign rx_avail = rxav_q;
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
   parameter int VEC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ev_rxc,
   input logic             cfg_wr,
   input logic             cfg_mie,
   input logic             iack,
   input logic             irq_clr,
   input logic             irq,
   input logic [VEC_W-1:0] vec,
   input logic [3:0]       pend,
   input logic             rx_avail
);
   // R1: reset state while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (pend == 4'd0 && !irq && !rx_avail && vec == '0);
      end
   end

   // R2: turning the master enable off silences the request next cycle
   a_r2_mie_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !cfg_mie) |=> !irq);

   // R3: a request always has a pending cause behind it
   a_r3_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (pend != 4'd0));

   // R7: every received byte leaves the status flag set
   a_r7_rx_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rxc |=> rx_avail);

   // R9: vector held steady through a long acknowledge
   a_r9_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
      (iack && $past(iack)) |=> $stable(vec));

   // R12: without an end-of-service strobe no pending bit drops
   a_r12_no_silent_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_clr |=> ((pend & $past(pend)) == $past(pend)));

   // R12: one strobe drops at most one pending bit
   a_r12_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr |=> ($countones($past(pend) & ~pend) <= 1));
endmodule

bind vec_irq_ctrl vic_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/sim_vec_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vec_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_txe = 0, ev_ext = 0, ev_rxc = 0, ev_spc = 0;
   logic       rx_take = 0, rx_rearm = 0;
   logic       cfg_wr = 0, cfg_mie = 0, cfg_vis = 0, cfg_txe_en = 0, cfg_ext_en = 0;
   logic [1:0] cfg_rx_mode = 2'b00;
   logic [7:0] cfg_base = 8'h00;
   logic       iack = 0, irq_clr = 0;
   logic       irq;
   logic [7:0] vec;
   logic [3:0] pend;
   logic       rx_avail;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   vec_irq_ctrl u0 (.*);

   // bench model state, built from the requirements
   logic       m_mie = 0, m_vis = 0, m_txe = 0, m_ext = 0;
   logic [1:0] m_rxm = 0;
   logic [7:0] m_base = 0, m_vec = 0;
   logic [3:0] m_pend = 0;
   logic       m_arm = 1, m_rxav = 0, m_iackq = 0, m_servv = 0;
   logic [1:0] m_serv = 0;

   function automatic logic [1:0] top_of(logic [3:0] p);
      if (p[3]) return 2'd3;       // R8 order
      if (p[2]) return 2'd2;
      if (p[0]) return 2'd0;
      return 2'd1;
   endfunction

   function automatic logic [7:0] vec_of(logic [7:0] b, logic v, logic [3:0] p);
      if (!v || p == 4'd0) return b;                   // R11
      return {b[7:4], 1'b1, top_of(p), b[0]};           // R10
   endfunction

   task automatic model_step();
      logic [3:0] set, clr;
      logic take;
      take   = ev_rxc && m_rxm == 2'b01 && m_arm;
      set[0] = ev_txe & m_txe;
      set[1] = ev_ext & m_ext;
      set[2] = (ev_rxc & m_rxm[1]) | take;
      set[3] = ev_spc & (m_rxm != 2'b00);
      clr    = 4'd0;
      if (irq_clr && m_servv) clr[m_serv] = 1'b1;
      if (iack && !m_iackq) begin
         m_vec   = vec_of(m_base, m_vis, m_pend);
         m_serv  = top_of(m_pend);
         m_servv = (m_pend != 4'd0);
      end else if (irq_clr) begin
         m_servv = 1'b0;
      end
      m_pend  = (m_pend & ~clr) | set;
      m_arm   = rx_rearm ? 1'b1 : (take ? 1'b0 : m_arm);
      m_rxav  = ev_rxc ? 1'b1 : (rx_take ? 1'b0 : m_rxav);
      m_iackq = iack;
      if (cfg_wr) begin
         m_mie = cfg_mie; m_vis = cfg_vis; m_txe = cfg_txe_en;
         m_ext = cfg_ext_en; m_rxm = cfg_rx_mode; m_base = cfg_base;
      end
   endtask

   task automatic check(string tag);
      logic e_irq;
      e_irq = m_mie & (m_pend != 4'd0);
      n_chk += 4;
      if (irq !== e_irq) begin
         n_bad++; $display("FAIL %s irq got %0b exp %0b", tag, irq, e_irq);
      end
      if (pend !== m_pend) begin
         n_bad++; $display("FAIL %s pend got %h exp %h", tag, pend, m_pend);
      end
      if (vec !== m_vec) begin
         n_bad++; $display("FAIL %s vec got %h exp %h", tag, vec, m_vec);
      end
      if (rx_avail !== m_rxav) begin
         n_bad++; $display("FAIL %s rx_avail got %0b exp %0b", tag, rx_avail, m_rxav);
      end
   endtask

   task automatic idle();
      ev_txe = 0; ev_ext = 0; ev_rxc = 0; ev_spc = 0; rx_take = 0; rx_rearm = 0;
      cfg_wr = 0; irq_clr = 0;
   endtask

   // apply the current inputs for one edge, then compare
   task automatic tick(string tag);
      model_step();
      @(posedge clk);
      #1;
      check(tag);
      idle();
   endtask

   task automatic setcfg(logic mie, logic vis, logic te, logic ee, logic [1:0] rm, logic [7:0] b, string tag);
      cfg_wr = 1; cfg_mie = mie; cfg_vis = vis; cfg_txe_en = te; cfg_ext_en = ee;
      cfg_rx_mode = rm; cfg_base = b;
      tick(tag);
   endtask

   task automatic serve(string tag);
      iack = 1; tick(tag);
      tick(tag);
      iack = 0; irq_clr = 1; tick(tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1");
      rst_n = 1;
      tick("R1");

      // R2: master enable off, events still latch
      setcfg(0, 1, 1, 1, 2'b10, 8'h20, "R2");
      ev_txe = 1; tick("R2");
      setcfg(1, 1, 1, 1, 2'b10, 8'h20, "R2");
      tick("R3");
      serve("R12");

      // R8/R10: all four pending, served in priority order
      ev_txe = 1; ev_ext = 1; ev_rxc = 1; ev_spc = 1; tick("R3");
      iack = 1; tick("R9"); tick("R9"); tick("R9");
      iack = 0; irq_clr = 1; tick("R10");
      serve("R8"); serve("R8"); serve("R10");
      // R11: nothing pending gives the base; stray clear ignored
      serve("R11");
      irq_clr = 1; tick("R12");
      // R12: acknowledge alone keeps the bit
      ev_txe = 1; tick("R12");
      iack = 1; tick("R12"); iack = 0; tick("R12"); tick("R12");
      ev_txe = 1; irq_clr = 1; tick("R12");
      irq_clr = 1; tick("R12");

      // R4: individual source enables
      setcfg(1, 1, 1, 0, 2'b10, 8'h20, "R4");
      ev_ext = 1; tick("R4");
      setcfg(1, 1, 0, 1, 2'b10, 8'h20, "R4");
      ev_txe = 1; tick("R4"); ev_ext = 1; tick("R4");
      serve("R4");

      // R5: receive mode off blocks both receive sources
      setcfg(1, 1, 1, 1, 2'b00, 8'h20, "R5");
      ev_rxc = 1; ev_spc = 1; tick("R5");
      rx_take = 1; tick("R7");
      // R6: first-byte mode
      setcfg(1, 1, 1, 1, 2'b01, 8'h20, "R6");
      ev_rxc = 1; tick("R6");
      serve("R6");
      ev_rxc = 1; tick("R6");
      ev_rxc = 1; rx_take = 1; tick("R7");
      rx_take = 1; tick("R7");
      rx_rearm = 1; tick("R6");
      ev_rxc = 1; rx_rearm = 1; tick("R6");
      serve("R6");
      ev_rxc = 1; tick("R6");
      ev_spc = 1; tick("R5");
      serve("R5");
      serve("R6");

      // R11: status inclusion off
      setcfg(1, 0, 1, 1, 2'b10, 8'h5B, "R11");
      ev_spc = 1; tick("R11");
      serve("R11");

      // constrained random phase
      begin
         int unsigned seed_v;
         seed_v = $urandom(32'h1C0FFEE);
         for (int k = 0; k < 4000; k++) begin
            ev_txe   = ($urandom % 5) == 0;
            ev_ext   = ($urandom % 5) == 0;
            ev_rxc   = ($urandom % 5) == 0;
            ev_spc   = ($urandom % 7) == 0;
            rx_take  = ($urandom % 6) == 0;
            rx_rearm = ($urandom % 10) == 0;
            irq_clr  = ($urandom % 6) == 0;
            if (($urandom % 4) == 0) iack = ~iack;
            if (($urandom % 40) == 0) begin
               cfg_wr      = 1;
               cfg_mie     = ($urandom % 5) != 0;
               cfg_vis     = ($urandom % 4) != 0;
               cfg_txe_en  = $urandom % 2;
               cfg_ext_en  = $urandom % 2;
               cfg_rx_mode = $urandom % 4;
               cfg_base    = $urandom % 256;
            end
            tick("R3");
         end
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(1_500_000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired got running exp finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule